// File: doc/BRIEF.md
# Multi-Line Clocked Glitch Filter

This block cleans up a group of parallel digital input lines that share one filter setting. Each raw line first passes through a two-flop synchronizer. A prescaler in the system clock domain then produces a shared sampling strobe. Its period is derived from a programmed minimum pulse width, counted in clock ticks (one tick is 25 ns at a 40 MHz timebase). A filtered line takes a new level only when two consecutive strobes have both sampled the new level. Short glitches are therefore dropped on both the rising and the falling edge.

The strobe spacing is about half the programmed width. A pulse lasting the full width always spans two strobes. A pulse shorter than half the width can cover at most one strobe. Pulses between those two bounds pass or fail depending on where the strobes fall. When the filter is turned off, the synchronized inputs drive the outputs directly.

Top module: `glitch_filter_bank`

## Requirements
- R1: The strobe acts once every P clock cycles, where P = max(1, floor(W/2)) and W is the programmed width in ticks. After a restart, the first strobe acts P cycles after the restart cycle.
- R2: With `filt_en` low, `filt_out` equals `raw_in` from two clock cycles earlier, and no glitch is removed.
- R3: With the filter on, a line changes only on the second of two consecutive strobes that both sample the new level. A strobe that samples the old level cancels any pending qualification.
- R4: With the filter on and W >= 2, a pulse on a line shorter than W/2 cycles never appears on `filt_out`.
- R5: With the filter on and W >= 2, a pulse lasting at least W cycles always appears on `filt_out`. A steady level change reaches `filt_out` no later than 2P+2 clock cycles after it is applied.
- R6: Rising and falling pulses obey the same rule, and each line is filtered independently while all lines run at once.
- R7: While `rst` is high, each filtered level is loaded with its synchronized input. An input held for at least three reset cycles is therefore present on `filt_out` immediately after reset.
- R8: A change of `min_width` restarts the prescaler on the next clock edge and loads each filtered level with its synchronized input. No strobe acts on that edge.
- R9: While bypassed, the filtered levels track the synchronized inputs. Turning the filter on therefore causes no change on `filt_out`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System timebase clock |
| rst | input | 1 | Synchronous reset, active high |
| filt_en | input | 1 | 1 = filter active, 0 = synchronized bypass |
| min_width | input | WIDTH_W | Minimum guaranteed-pass pulse width in clock ticks |
| raw_in | input | LINES | Raw input lines |
| filt_out | output | LINES | Filtered output lines |

## Verification
The bench builds the block with its default eight lines and a 16-bit width setting. It runs random rounds at widths 8 and 12, giving strobe periods of 4 and 6. These rounds mix sub-half-width glitches, full-width pulses and idle lines on all eight lines at once, starting from random levels, so rising and falling pulses run side by side. A width change from 8 to 9 keeps the period at 4 but restarts the prescaler at a known cycle. This makes the strobe phase known to the bench, so an alternating half-width pattern can be aimed exactly at the cancellation rule. Moving the width to 100 shows the reload taking effect before any strobe could have qualified the new level.

// File: rtl/glitch_filter_bank.sv
module glitch_filter_bank #(
  parameter int LINES   = 8,
  parameter int WIDTH_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               filt_en,
  input  logic [WIDTH_W-1:0] min_width,
  input  logic [LINES-1:0]   raw_in,
  output logic [LINES-1:0]   filt_out
);

  localparam logic [WIDTH_W-1:0] ONE = {{(WIDTH_W-1){1'b0}}, 1'b1};

  logic [LINES-1:0]   meta, sync, hold, cand;
  logic [WIDTH_W-1:0] width_q, cnt, period;
  logic               reload, strobe;

  assign period   = (width_q > ONE) ? (width_q >> 1) : ONE;
  assign reload   = rst || (width_q != min_width);
  assign strobe   = !reload && (cnt == period - ONE);
  assign filt_out = filt_en ? hold : sync;

  always_ff @(posedge clk) begin
    meta    <= raw_in;
    sync    <= meta;
    width_q <= min_width;
    if (reload || strobe) cnt <= '0;
    else                  cnt <= cnt + ONE;
  end

  always_ff @(posedge clk) begin
    if (reload || !filt_en) begin
      hold <= sync;
      cand <= '0;
    end else if (strobe) begin
      cand <= (sync ^ hold) & ~cand;
      hold <= hold ^ ((sync ^ hold) & cand);
    end
  end

  // a line may flip only if it was already qualified by the previous strobe
  assert_two_strobes_R3: assert property (@(posedge clk) disable iff (rst)
    (!$past(reload) && $past(filt_en)) |-> (((hold ^ $past(hold)) & ~$past(cand)) == '0));

  assert_only_on_strobe_R3: assert property (@(posedge clk) disable iff (rst)
    (!reload && filt_en && !strobe) |=> $stable(hold));

  assert_bypass_delay_R2: assert property (@(posedge clk) disable iff (rst)
    !filt_en |-> (filt_out == $past(raw_in, 2)));

  assert_reload_loads_R8: assert property (@(posedge clk) disable iff (rst)
    reload |=> (hold == $past(sync)));

  assert_strobe_gap_R1: assert property (@(posedge clk) disable iff (rst)
    (strobe && period > ONE) |=> !strobe);

endmodule

// File: tb/glitch_filter_bank_tb_top.sv
`timescale 1ns/1ps
module glitch_filter_bank_tb_top;
  localparam int LINES = 8;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             filt_en = 1'b1;
  logic [15:0]      min_width = 16'd8;
  logic [LINES-1:0] raw_in = '0;
  logic [LINES-1:0] filt_out;

  int checks = 0;
  int errors = 0;
  logic             mon_on = 1'b0;
  logic [LINES-1:0] base = '0;
  logic [LINES-1:0] chg = '0;

  glitch_filter_bank #(.LINES(LINES), .WIDTH_W(16)) dut_i (
    .clk(clk), .rst(rst), .filt_en(filt_en), .min_width(min_width),
    .raw_in(raw_in), .filt_out(filt_out));

  always #2.5 clk = ~clk;

  always @(negedge clk) if (mon_on) chg <= chg | (filt_out ^ base);

  task automatic chk(input string req, input logic [LINES-1:0] act, input logic [LINES-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic settle(input logic [LINES-1:0] lvl);
    raw_in = lvl;
    repeat (40) @(negedge clk);
  endtask

  function automatic int half_of(input int w);
    return (w / 2 < 1) ? 1 : w / 2;
  endfunction

  task automatic random_round(input int w, input int iters);
    int p;
    int kind [LINES];
    int st [LINES];
    int ln [LINES];
    logic [LINES-1:0] sh, lg, idle, v;
    p = half_of(w);
    min_width = w[15:0];
    for (int it = 0; it < iters; it++) begin
      settle($urandom);
      chk("R6 settled level", filt_out, raw_in);
      base = filt_out;
      sh = '0; lg = '0; idle = '0;
      for (int i = 0; i < LINES; i++) begin
        kind[i] = $urandom % 3;
        st[i]   = $urandom % 8;
        ln[i]   = (kind[i] == 1) ? 1 + ($urandom % (p - 1)) : w + ($urandom % 5);
        if (kind[i] == 0) idle[i] = 1'b1;
        if (kind[i] == 1) sh[i] = 1'b1;
        if (kind[i] == 2) lg[i] = 1'b1;
      end
      chg = '0;
      mon_on = 1'b1;
      for (int t = 0; t < 8 + w + 5; t++) begin
        @(negedge clk);
        v = base;
        for (int i = 0; i < LINES; i++)
          if (kind[i] != 0 && t >= st[i] && t < st[i] + ln[i]) v[i] = ~base[i];
        raw_in = v;
      end
      repeat (2 * w + 10) @(negedge clk);
      mon_on = 1'b0;
      chk("R4 short pulses rejected", chg & sh, '0);
      chk("R5 long pulses passed", chg & lg, lg);
      chk("R6 idle lines quiet", chg & idle, '0);
      chk("R6 returned to base", filt_out, base);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    raw_in = 8'hA5;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R7 reset loads input", filt_out, 8'hA5);

    // R2 bypass: two-cycle delay, no filtering
    filt_en = 1'b0;
    repeat (3) @(negedge clk);
    raw_in = 8'h3C;
    @(negedge clk);
    chk("R2 bypass one cycle", filt_out, 8'hA5);
    @(negedge clk);
    chk("R2 bypass two cycles", filt_out, 8'h3C);
    raw_in = 8'hC3;
    @(negedge clk);
    raw_in = 8'h3C;
    @(negedge clk);
    chk("R2 bypass glitch visible", filt_out, 8'hC3);
    @(negedge clk);
    chk("R2 bypass glitch gone", filt_out, 8'h3C);

    // R9 enabling causes no change
    raw_in = 8'h96;
    repeat (4) @(negedge clk);
    base = 8'h96; chg = '0; mon_on = 1'b1;
    filt_en = 1'b1;
    repeat (15) @(negedge clk);
    mon_on = 1'b0;
    chk("R9 enable no change", chg, '0);
    chk("R9 enable keeps level", filt_out, 8'h96);

    // R5 latency bound, P=4: 2P+2 = 10 cycles
    settle(8'h0F);
    raw_in = 8'hF0;
    repeat (10) @(negedge clk);
    chk("R5 step latency", filt_out, 8'hF0);

    // R3/R1 phase-aligned cancellation after restart
    settle(8'h00);
    @(negedge clk);
    min_width = 16'd9;
    base = 8'h00; chg = '0; mon_on = 1'b1;
    for (int j = 1; j <= 16; j++) begin
      @(negedge clk);
      raw_in = (((j - 1) / 4) % 2 == 0) ? 8'h01 : 8'h00;
    end
    raw_in = 8'h00;
    repeat (20) @(negedge clk);
    mon_on = 1'b0;
    chk("R3 alternating samples cancel", chg, '0);
    chk("R1 restart phase", filt_out, 8'h00);

    // R8 width change reload
    min_width = 16'd8;
    settle(8'h00);
    raw_in = 8'hFF;
    repeat (2) @(negedge clk);
    chk("R8 before reload", filt_out, 8'h00);
    min_width = 16'd100;
    @(negedge clk);
    chk("R8 reload takes sync", filt_out, 8'hFF);
    min_width = 16'd8;
    settle(8'hFF);

    random_round(8, 40);
    random_round(12, 30);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule